// File: doc/BRIEF.md
# Stepped-Trigger Waveform Sequencer

This block plays a preloaded list of waveform segments out of a sample memory. Each entry of a small step table names a segment by its first address and its length in samples, together with how many times that segment is repeated. Once enabled, the sequencer sits idle until a trigger edge arrives. It then plays the current step's segment back-to-back for the configured number of passes. After the final pass it freezes the output on the segment's last sample. Each later trigger moves it to the next entry in the list.

Once the last configured step has finished, the sequencer holds and flags completion. The next trigger starts the whole list again from entry zero. Sample memory is read through a simple request/valid pair: one read per clock while a segment plays, with data returned a fixed number of cycles later. The returned sample is registered onto the output together with a one-cycle valid strobe. Two status outputs report the controller state and the index of the current step.

Top module: `wseq_top`

## Requirements
- R1: While `rst_n` is low, `state_o` reads 0 (idle), `step_o` 0, `sample_out` 0, and `sample_vld`, `done` and `mem_rd` are all low.
- R2: With `run` high the block enters the waiting state (`state_o` = 1) and issues no memory read until a rising edge on `trig`. That edge starts step 0 (`state_o` = 2, playing).
- R3: A playing step reads addresses start, start+1 … start+len-1 in order and repeats that pass loops times. A loop count of 0 is played as 1, and a length of 0 is played as 1. Every returned sample appears on `sample_out` with `sample_vld` high, exactly once and in order.
- R4: Reads run without gap cycles, including across a pass boundary: one step yields len×loops consecutive cycles of `sample_vld`.
- R5: After the final pass the block enters the holding state (`state_o` = 3). `sample_out` keeps the segment's last sample and `sample_vld` stays low until the next trigger edge.
- R6: A trigger edge in the holding state starts the next table entry, and `step_o` shows its index.
- R7: A trigger edge while a step is playing is ignored: it does not change the step, does not shorten or restart the pass, and is not remembered afterwards.
- R8: `done` is high in the holding state once step `seq_last` has finished. The next trigger edge clears it and restarts at step 0.
- R9: Driving `run` low returns the block to the idle state with `step_o` = 0. Trigger edges have no effect there, and the next enable starts again from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the sequencer; low forces idle |
| trig | input | 1 | Trigger; its rising edge is acted on |
| tbl_we | input | 1 | Step table write strobe |
| tbl_idx | input | STEP_W | Table entry to write |
| tbl_start | input | ADDR_W | Segment first address |
| tbl_len | input | LEN_W | Segment length in samples |
| tbl_loops | input | LOOP_W | Number of passes over the segment |
| seq_last | input | STEP_W | Index of the final step in the list |
| mem_rd | output | 1 | Read request, one per playing cycle |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| sample_out | output | DATA_W | Current output sample |
| sample_vld | output | 1 | Pulses when a new sample is placed on `sample_out` |
| state_o | output | 2 | 0 idle, 1 waiting, 2 playing, 3 holding |
| step_o | output | STEP_W | Index of the current step |
| done | output | 1 | Whole list finished, holding |

## Verification
The bench targets the pass boundary, where a design that reloads the start address one cycle late leaves a hole in the valid stream or repeats a sample. It also tries a zero loop count combined with a zero length, which a naive counter would turn into a very long or empty run. A trigger fired in the middle of a playing step must not skip ahead or be queued into a premature next step. The bench checks the wrap after the last step back to entry zero, and that dropping `run` really discards progress instead of resuming at the old step.

// File: rtl/wseq_pkg.sv
// Shared types for the stepped-trigger waveform sequencer.
// Assumes nothing beyond a 2-bit status encoding seen at the top ports.
package wseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PLAY = 2'd2,
        ST_HOLD = 2'd3
    } wseq_state_e;
endpackage

// File: rtl/wseq_step_table.sv
// Step table: STEPS entries of {start, length, loops}, written one at a time
// and read combinationally by the current step index. Zero length and zero
// loop count are mapped to one on the read side (delivered minus one).
// Assumes STEPS is a power of two so the index covers the array exactly.
module wseq_step_table #(
    parameter int STEPS  = 16,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12,
    parameter int LOOP_W = 16,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STEP_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [LOOP_W-1:0] wr_loops,
    input  logic [STEP_W-1:0] rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [LEN_W-1:0]  rd_len_m1,
    output logic [LOOP_W-1:0] rd_loops_m1
);
    logic [ADDR_W-1:0] start_a [STEPS];
    logic [LEN_W-1:0]  len_a   [STEPS];
    logic [LOOP_W-1:0] loops_a [STEPS];

    for (genvar g = 0; g < STEPS; g++) begin : g_ent
        logic [ADDR_W-1:0] start_q;
        logic [LEN_W-1:0]  len_q;
        logic [LOOP_W-1:0] loops_q;

        // Capture one entry when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q <= '0;
                len_q   <= '0;
                loops_q <= '0;
            end else if (wr_en && (wr_idx == STEP_W'(g))) begin
                start_q <= wr_start;
                len_q   <= wr_len;
                loops_q <= wr_loops;
            end
        end

        assign start_a[g] = start_q;
        assign len_a[g]   = len_q;
        assign loops_a[g] = loops_q;
    end

    logic [LEN_W-1:0]  sel_len;
    logic [LOOP_W-1:0] sel_loops;

    // Select the current entry and turn counts into last-index form.
    always_comb begin
        rd_start    = start_a[rd_idx];
        sel_len     = len_a[rd_idx];
        sel_loops   = loops_a[rd_idx];
        rd_len_m1   = (sel_len == '0)   ? '0 : sel_len - LEN_W'(1);
        rd_loops_m1 = (sel_loops == '0) ? '0 : sel_loops - LOOP_W'(1);
    end
endmodule

// File: rtl/wseq_addr_gen.sv
// Address generator: walks a segment sample by sample and counts passes.
// Flags the cycle that reads the final sample of the final pass.
// Assumes load and advance are never high together (load only outside play).
module wseq_addr_gen #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [LOOP_W-1:0] loops_m1,
    output logic [ADDR_W-1:0] addr,
    output logic              last_smp
);
    logic [LEN_W-1:0]  idx_q;
    logic [LOOP_W-1:0] pass_q;
    logic              wrap;

    // Offset into the segment and end-of-pass / end-of-step flags.
    always_comb begin
        wrap     = (idx_q == len_m1);
        last_smp = wrap && (pass_q == loops_m1);
        addr     = base + ADDR_W'(idx_q);
    end

    // Sample index and pass counter; wrap to 0 with no idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            pass_q <= '0;
        end else if (load) begin
            idx_q  <= '0;
            pass_q <= '0;
        end else if (advance) begin
            if (wrap) begin
                idx_q  <= '0;
                pass_q <= pass_q + LOOP_W'(1);
            end else begin
                idx_q  <= idx_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/wseq_fsm.sv
// Sequencer control: idle / waiting / playing / holding, plus step index.
// Trigger edges are acted on only while waiting or holding.
// Assumes trig_fire is a one-cycle pulse per trigger edge.
module wseq_fsm
    import wseq_pkg::*;
#(
    parameter int STEPS = 16,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              trig_fire,
    input  logic              last_smp,
    input  logic [STEP_W-1:0] seq_last,
    output wseq_state_e       state,
    output logic [STEP_W-1:0] step,
    output logic              load,
    output logic              done
);
    wseq_state_e       st_d;
    logic [STEP_W-1:0] stp_d;

    // Next-state, next-step and segment-load decision.
    always_comb begin
        st_d  = state;
        stp_d = step;
        load  = 1'b0;
        if (!run) begin
            st_d  = ST_IDLE;
            stp_d = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    st_d  = ST_WAIT;
                    stp_d = '0;
                end
                ST_WAIT: begin
                    if (trig_fire) begin
                        st_d = ST_PLAY;
                        load = 1'b1;
                    end
                end
                ST_PLAY: begin
                    if (last_smp) st_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (trig_fire) begin
                        st_d  = ST_PLAY;
                        load  = 1'b1;
                        stp_d = (step >= seq_last) ? '0 : step + STEP_W'(1);
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= st_d;
            step  <= stp_d;
        end
    end

    // Completion flag: holding after the final step of the list.
    always_comb done = (state == ST_HOLD) && (step >= seq_last);
endmodule

// File: rtl/wseq_top.sv
// Stepped-trigger waveform sequencer top: step table, address generator,
// control FSM, trigger edge detect and the output sample register.
// Assumes a sample memory that answers each mem_rd with exactly one
// mem_rvalid at a fixed latency, so back-to-back reads give gap-free output.
module wseq_top
    import wseq_pkg::*;
#(
    parameter int STEPS  = 16,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12,
    parameter int LOOP_W = 16,
    parameter int DATA_W = 16,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              trig,
    input  logic              tbl_we,
    input  logic [STEP_W-1:0] tbl_idx,
    input  logic [ADDR_W-1:0] tbl_start,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic [LOOP_W-1:0] tbl_loops,
    input  logic [STEP_W-1:0] seq_last,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] sample_out,
    output logic              sample_vld,
    output logic [1:0]        state_o,
    output logic [STEP_W-1:0] step_o,
    output logic              done
);
    wseq_state_e       state;
    logic [STEP_W-1:0] step;
    logic              load;
    logic              last_smp;
    logic              trig_q;
    logic              trig_fire;
    logic [ADDR_W-1:0] cur_start;
    logic [LEN_W-1:0]  cur_len_m1;
    logic [LOOP_W-1:0] cur_loops_m1;

    // Remember last trigger level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    always_comb trig_fire = trig && !trig_q;

    wseq_step_table #(
        .STEPS(STEPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_start(tbl_start),
        .wr_len(tbl_len), .wr_loops(tbl_loops),
        .rd_idx(step), .rd_start(cur_start),
        .rd_len_m1(cur_len_m1), .rd_loops_m1(cur_loops_m1)
    );

    wseq_fsm #(.STEPS(STEPS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .run(run), .trig_fire(trig_fire),
        .last_smp(last_smp), .seq_last(seq_last),
        .state(state), .step(step), .load(load), .done(done)
    );

    wseq_addr_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W)
    ) agen_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .advance(state == ST_PLAY),
        .base(cur_start), .len_m1(cur_len_m1), .loops_m1(cur_loops_m1),
        .addr(mem_addr), .last_smp(last_smp)
    );

    // One read request per playing cycle.
    always_comb mem_rd = (state == ST_PLAY);

    // Output sample register: update on returned data, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= mem_rvalid;
            if (mem_rvalid) sample_out <= mem_rdata;
        end
    end

    // Status outputs.
    always_comb begin
        state_o = state;
        step_o  = step;
    end
endmodule

// File: rtl/wseq_chk.sv
// Property checker for wseq_top, attached with bind below.
// Assumes the 2-bit state encoding 0 idle, 1 waiting, 2 playing, 3 holding.
module wseq_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [1:0]        state_o,
    input logic [STEP_W-1:0] step_o,
    input logic [DATA_W-1:0] sample_out,
    input logic              sample_vld,
    input logic              done,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cur_start
);
    AST_PLAY_STEP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && run) |=> (step_o == $past(step_o))); // R7

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) == 2'd3 && $past(state_o, 2) == 2'd3)
        |-> (!sample_vld && $stable(sample_out))); // R5

    AST_RD_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && $stable(step_o))
        |-> (mem_addr == $past(mem_addr) + ADDR_W'(1) || mem_addr == cur_start)); // R4

    AST_DONE_AFTER_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_o) == 2'd2)); // R8

    AST_RUN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_o == 2'd0 && step_o == '0)); // R9
endmodule

bind wseq_top wseq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .state_o(state_o), .step_o(step_o),
    .sample_out(sample_out), .sample_vld(sample_vld), .done(done),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .cur_start(cur_start)
);

// File: tb/wseq_top_tb_top.sv
// Scoreboard bench: the driver pushes the samples each step must produce,
// the monitor pops and compares as sample_vld appears.
module wseq_top_tb_top;
    localparam int STEPS  = 16;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 12;
    localparam int LOOP_W = 16;
    localparam int DATA_W = 16;
    localparam int STEP_W = $clog2(STEPS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              trig = 1'b0;
    logic              tbl_we = 1'b0;
    logic [STEP_W-1:0] tbl_idx = '0;
    logic [ADDR_W-1:0] tbl_start = '0;
    logic [LEN_W-1:0]  tbl_len = '0;
    logic [LOOP_W-1:0] tbl_loops = '0;
    logic [STEP_W-1:0] seq_last = STEP_W'(2);
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [DATA_W-1:0] sample_out;
    logic              sample_vld;
    logic [1:0]        state_o;
    logic [STEP_W-1:0] step_o;
    logic              done;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int vld_cnt = 0;
    int cur_run = 0;
    int last_run = 0;
    logic [DATA_W-1:0] exp_q[$];

    int b_start [3] = '{10, 100, 200};
    int b_len   [3] = '{4, 0, 5};
    int b_loops [3] = '{2, 0, 3};

    always #5 clk = ~clk;

    wseq_top #(
        .STEPS(STEPS), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .LOOP_W(LOOP_W), .DATA_W(DATA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .trig(trig),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_start(tbl_start),
        .tbl_len(tbl_len), .tbl_loops(tbl_loops), .seq_last(seq_last),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .sample_out(sample_out), .sample_vld(sample_vld),
        .state_o(state_o), .step_o(step_o), .done(done)
    );

    function automatic logic [DATA_W-1:0] mem_val(input int a);
        return DATA_W'(a * 37 + 11);
    endfunction

    // Sample memory model: one-cycle read latency.
    always @(posedge clk) begin
        mem_rvalid <= rst_n && mem_rd;
        mem_rdata  <= mem_val(int'(mem_addr));
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare each produced sample against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (sample_vld) begin
                vld_cnt++;
                cur_run++;
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R3: actual unexpected sample %0d expected none",
                             sample_out);
                end else begin
                    chk("R3 sample order", int'(sample_out), int'(exp_q.pop_front()));
                end
            end else if (cur_run > 0) begin
                last_run = cur_run;
                cur_run  = 0;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_entry(input int i, input int s, input int l, input int lp);
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_idx   = STEP_W'(i);
        tbl_start = ADDR_W'(s);
        tbl_len   = LEN_W'(l);
        tbl_loops = LOOP_W'(lp);
        @(negedge clk);
        tbl_we    = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Driver: push the expected samples of a step, then fire its trigger.
    task automatic play_step(input int s);
        int l  = (b_len[s] == 0) ? 1 : b_len[s];
        int lp = (b_loops[s] == 0) ? 1 : b_loops[s];
        for (int p = 0; p < lp; p++)
            for (int i = 0; i < l; i++)
                exp_q.push_back(mem_val(b_start[s] + i));
        pulse_trig();
    endtask

    function automatic int step_total(input int s);
        return ((b_len[s] == 0) ? 1 : b_len[s]) * ((b_loops[s] == 0) ? 1 : b_loops[s]);
    endfunction

    function automatic int last_val(input int s);
        int l = (b_len[s] == 0) ? 1 : b_len[s];
        return int'(mem_val(b_start[s] + l - 1));
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rd_snap;
        int vld_snap;
        cyc(3);
        // R1: reset values
        chk("R1 state", state_o, 0);
        chk("R1 step", step_o, 0);
        chk("R1 sample", sample_out, 0);
        chk("R1 flags", {sample_vld, done, mem_rd}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) write_entry(i, b_start[i], b_len[i], b_loops[i]);
        write_entry(3, 300, 7, 7);

        // R2: enable waits for a trigger, reads nothing
        run = 1'b1;
        cyc(6);
        chk("R2 waiting", state_o, 1);
        chk("R2 no reads", rd_cnt, 0);

        // R3 R4 R5: step 0, 4 samples x 2 passes
        play_step(0);
        chk("R2 playing", state_o, 2);
        cyc(step_total(0) + 4);
        chk("R5 holding", state_o, 3);
        chk("R5 last sample", sample_out, last_val(0));
        chk("R4 gap-free run", last_run, step_total(0));
        chk("R3 all consumed", exp_q.size(), 0);
        chk("R8 not done", done, 0);
        vld_snap = vld_cnt;
        cyc(10);
        chk("R5 no new samples", vld_cnt, vld_snap);
        chk("R5 sample held", sample_out, last_val(0));

        // R6 R3: step 1, zero length and zero loops play once
        play_step(1);
        cyc(step_total(1) + 4);
        chk("R6 step index", step_o, 1);
        chk("R3 zero counts run", last_run, 1);
        chk("R5 last sample", sample_out, last_val(1));

        // R7: trigger in mid-play of step 2 is ignored
        play_step(2);
        cyc(3);
        pulse_trig();
        chk("R7 still playing", state_o, 2);
        chk("R7 step unchanged", step_o, 2);
        cyc(step_total(2) + 4);
        chk("R7 full run", last_run, step_total(2));
        chk("R7 holding", state_o, 3);
        chk("R8 done", done, 1);
        vld_snap = vld_cnt;
        cyc(6);
        chk("R7 not queued", vld_cnt, vld_snap);

        // R8: restart from step 0
        play_step(0);
        chk("R8 done cleared", done, 0);
        cyc(step_total(0) + 4);
        chk("R8 restart step", step_o, 0);
        chk("R8 restart run", last_run, step_total(0));
        chk("R3 all consumed", exp_q.size(), 0);

        // R9: run low forces idle; trigger has no effect there
        play_step(1);
        cyc(5);
        run = 1'b0;
        cyc(2);
        chk("R9 idle", state_o, 0);
        chk("R9 step reset", step_o, 0);
        rd_snap  = rd_cnt;
        vld_snap = vld_cnt;
        pulse_trig();
        cyc(4);
        chk("R9 ignored reads", rd_cnt, rd_snap);
        chk("R9 ignored samples", vld_cnt, vld_snap);
        run = 1'b1;
        cyc(3);
        chk("R9 waiting again", state_o, 1);
        play_step(0);
        cyc(step_total(0) + 4);
        chk("R9 restarts at 0", step_o, 0);
        chk("R9 run length", last_run, step_total(0));
        chk("R3 all consumed", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule